// File: doc/BRIEF.md
# Oscillator Loss Monitor With Internal-Clock Fallback

This block supervises two external oscillators: a low-frequency crystal clock and a high-frequency crystal clock. It runs entirely on the always-running internal reference oscillator. Each monitored clock is brought into the reference domain and its rising edges restart a per-source silence timer. The timer spans 50 microseconds, and the number of reference cycles is derived from the reference frequency parameter. When a source stays silent past that window it is marked faulty.

When the source feeding the main system clock fails, the block drives a registered override that makes the downstream clock mux select the internal oscillator. A fault on either source sets a sticky fault flag. The flag, ANDed with an enable bit, forms a level interrupt. Software reaches the enable, the flag, live per-source status and an override-release command through a three-register write/read port. The flag can be cleared only once the fault has gone. The override is handed back only on request, after the flag is clear and the selected source is healthy again.

Top module: `osc_fault_guard`

## Requirements
- R1: Each monitored clock passes through a SYNC_STAGES-flop synchroniser, and only its rising edges count as activity. The timeout is T = REF_KHZ*TIMEOUT_US/1000 reference cycles.
- R2: A source becomes live-faulted if and only if the spacing between its rising edges exceeds T reference cycles. A source toggling with a rising-edge period of T cycles or less never faults, including just after reset.
- R3: A live fault clears only when an edge arrives after at least T-1 cycles of activity with no gap over T. Until then the live status bit stays set.
- R4: A live fault on the source chosen by MAIN_SRC (0 = low-frequency, 1 = high-frequency) sets `main_on_ref` on the next cycle. A fault on the other source alone leaves `main_on_ref` low.
- R5: The sticky flag (register 1, bit 1) is set by a live fault on either source. Writing register 1 with bit 1 = 0 clears it only while no fault is live. Writing bit 1 = 1 has no effect.
- R6: `osc_fault_irq` is a level signal equal to the flag AND the enable (register 0, bit 1), delayed by one cycle.
- R7: Reads return data one cycle after the address. Register 0 holds the enable in bit 1. Register 1 holds the flag in bit 1, the low-frequency live fault in bit 2, the high-frequency live fault in bit 3 and the override in bit 4. Registers 2 and 3 and all other bits read zero.
- R8: Writing register 2 with bit 0 = 1 drops the override only while the flag is clear and the selected source is not faulted. Otherwise the request is ignored.
- R9: After reset the flag, the enable, the override, the interrupt and both live faults are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Internal reference oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_osc_in | input | 1 | Low-frequency crystal clock, asynchronous |
| hf_osc_in | input | 1 | High-frequency crystal clock, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| main_on_ref | output | 1 | 1 forces the main clock mux to the internal oscillator |
| osc_fault_irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with REF_KHZ = 200 and TIMEOUT_US = 50, which gives a 10-cycle timeout, and with MAIN_SRC = 0. With a timeout that short, every rising-edge period from 2 to 14 cycles on each source can be swept from reset. That sweep lands exactly on both sides of the fault threshold and checks the status, flag and override predicted for each case. The same small window keeps the recovery, sticky-clear and override-release sequences within a few dozen cycles each.

// File: rtl/ofd_pkg.sv
package ofd_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;
  localparam int NUM_SRC = 2;

  localparam logic [ADDR_W-1:0] A_ENABLE = 2'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd1;
  localparam logic [ADDR_W-1:0] A_CLKCTL = 2'd2;

  localparam int B_IE      = 1;
  localparam int B_FLAG    = 1;
  localparam int B_LF_LIVE = 2;
  localparam int B_HF_LIVE = 3;
  localparam int B_OVR     = 4;
  localparam int B_RELEASE = 0;
endpackage

// File: rtl/ofd_sync_edge.sv
module ofd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_in};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ofd_miss_timer.sv
module ofd_miss_timer #(
  parameter int TIMEOUT_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic fault_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] miss_cnt;
  logic [CNT_W-1:0] good_cnt;
  logic             fault_q;
  logic             starve;

  assign starve = (miss_cnt == '0) && !edge_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_cnt <= RELOAD;
      good_cnt <= '0;
      fault_q  <= 1'b0;
    end else begin
      if (edge_i)
        miss_cnt <= RELOAD;
      else if (miss_cnt != '0)
        miss_cnt <= miss_cnt - 1'b1;

      if (starve)
        fault_q <= 1'b1;
      else if (fault_q && edge_i && good_cnt == RELOAD)
        fault_q <= 1'b0;

      if (starve || !fault_q)
        good_cnt <= '0;
      else if (good_cnt != RELOAD)
        good_cnt <= good_cnt + 1'b1;
    end
  end

  assign fault_o = fault_q;

  AST_EDGE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    edge_i |=> miss_cnt == RELOAD); // R2
  AST_STARVE_FAULTS: assert property (@(posedge clk) disable iff (rst)
    starve |=> fault_q); // R2
  AST_FAULT_NEEDS_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> $past(miss_cnt) == '0); // R2
  AST_RECOVER_FULL: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_q) |-> ($past(good_cnt) == RELOAD && $past(edge_i))); // R3
endmodule

// File: rtl/ofd_ctrl_regs.sv
module ofd_ctrl_regs
  import ofd_pkg::*;
#(
  parameter int MAIN_SRC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] fault_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic              on_ref_o
);
  localparam int OTHER_SRC = 1 - MAIN_SRC;

  logic ie_q, flag_q, force_q, irq_q;
  logic [DATA_W-1:0] rdata_q, rd_n;
  logic any_fault, sel_fault, clr_req, rel_req;

  assign any_fault = |fault_i;
  assign sel_fault = fault_i[MAIN_SRC];
  assign clr_req   = wr_en && (addr == A_STATUS) && !wdata[B_FLAG];
  assign rel_req   = wr_en && (addr == A_CLKCTL) && wdata[B_RELEASE];

  always_comb begin
    rd_n = '0;
    case (addr)
      A_ENABLE: rd_n[B_IE] = ie_q;
      A_STATUS: begin
        rd_n[B_FLAG]    = flag_q;
        rd_n[B_LF_LIVE] = fault_i[0];
        rd_n[B_HF_LIVE] = fault_i[1];
        rd_n[B_OVR]     = force_q;
      end
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      force_q <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_en && addr == A_ENABLE)
        ie_q <= wdata[B_IE];

      if (any_fault)
        flag_q <= 1'b1;
      else if (clr_req)
        flag_q <= 1'b0;

      if (sel_fault)
        force_q <= 1'b1;
      else if (rel_req && !flag_q)
        force_q <= 1'b0;

      irq_q   <= flag_q & ie_q;
      rdata_q <= rd_n;
    end
  end

  assign rdata    = rdata_q;
  assign irq_o    = irq_q;
  assign on_ref_o = force_q;

  AST_FLAG_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    any_fault |=> flag_q); // R5
  AST_FLAG_CLR_GUARD: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(clr_req && !any_fault)); // R5
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_q == $past(flag_q && ie_q)); // R6
  AST_FORCE_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    sel_fault |=> force_q); // R4
  AST_OTHER_NO_FORCE: assert property (@(posedge clk) disable iff (rst)
    (!force_q && !sel_fault && fault_i[OTHER_SRC]) |=> !force_q); // R4
  AST_RELEASE_GUARD: assert property (@(posedge clk) disable iff (rst)
    $fell(force_q) |-> $past(rel_req && !flag_q && !sel_fault)); // R8
endmodule

// File: rtl/osc_fault_guard.sv
module osc_fault_guard
  import ofd_pkg::*;
#(
  parameter int REF_KHZ     = 1000,
  parameter int TIMEOUT_US  = 50,
  parameter int SYNC_STAGES = 2,
  parameter int MAIN_SRC    = 0
) (
  input  logic              clk_ref,
  input  logic              rst,
  input  logic              lf_osc_in,
  input  logic              hf_osc_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              main_on_ref,
  output logic              osc_fault_irq
);
  localparam int TIMEOUT_CYC = REF_KHZ * TIMEOUT_US / 1000;

  logic [NUM_SRC-1:0] osc_vec;
  logic [NUM_SRC-1:0] rise_vec;
  logic [NUM_SRC-1:0] fault_vec;

  assign osc_vec = {hf_osc_in, lf_osc_in};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    ofd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk_ref),
      .rst      (rst),
      .async_in (osc_vec[g]),
      .rise_o   (rise_vec[g])
    );
    ofd_miss_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk     (clk_ref),
      .rst     (rst),
      .edge_i  (rise_vec[g]),
      .fault_o (fault_vec[g])
    );
  end

  ofd_ctrl_regs #(.MAIN_SRC(MAIN_SRC)) u_regs (
    .clk      (clk_ref),
    .rst      (rst),
    .fault_i  (fault_vec),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .irq_o    (osc_fault_irq),
    .on_ref_o (main_on_ref)
  );
endmodule

// File: tb/test_osc_fault_guard.sv
module test_osc_fault_guard;
  localparam int CLK_PERIOD = 10;
  localparam int REF_KHZ = 200;
  localparam int TIMEOUT_US = 50;
  localparam int T = REF_KHZ * TIMEOUT_US / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lf = 1'b0, hf = 1'b0;
  logic wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic on_ref, irq;

  int lf_per = 3, hf_per = 3, cyc = 0;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_fault_guard #(.REF_KHZ(REF_KHZ), .TIMEOUT_US(TIMEOUT_US), .SYNC_STAGES(2), .MAIN_SRC(0))
  i_osc_fault_guard (
    .clk_ref(clk), .rst(rst), .lf_osc_in(lf), .hf_osc_in(hf),
    .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .main_on_ref(on_ref), .osc_fault_irq(irq)
  );

  // pulse generators: one-cycle high pulse every N reference cycles, N = 0 means stuck low
  always @(negedge clk) begin
    #1;
    if (rst) begin
      cyc = 0; lf = 1'b0; hf = 1'b0;
    end else begin
      lf = (lf_per != 0) && (cyc % (lf_per == 0 ? 1 : lf_per) == 0);
      hf = (hf_per != 0) && (cyc % (hf_per == 0 ? 1 : hf_per) == 0);
      cyc = cyc + 1;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  function automatic logic [7:0] stat(input bit flag, input bit lfl, input bit hfl, input bit ovr);
    return {3'b000, ovr, hfl, lfl, flag, 1'b0};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=0x00 expected=0x01");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    // R9 reset state
    do_reset();
    wait_cyc(2);
    chk("R9 override", {7'b0, on_ref}, 8'h00);
    chk("R9 irq", {7'b0, irq}, 8'h00);
    rd_reg(2'd0, d); chk("R9 enable", d, 8'h00);
    rd_reg(2'd1, d); chk("R9 status", d, 8'h00);

    // R7 map and unused bits
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd0, d); chk("R7 enable reads bit1 only", d, 8'h02);
    rd_reg(2'd2, d); chk("R7 reg2 zero", d, 8'h00);
    rd_reg(2'd3, d); chk("R7 reg3 zero", d, 8'h00);

    // R1 R2 R4 R5 sweep of rising-edge periods around the threshold
    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 2; p <= 14; p++) begin
        bit f;
        lf_per = (ch == 0) ? p : 3;
        hf_per = (ch == 1) ? p : 3;
        do_reset();
        wait_cyc(4 * p + 20);
        f = (p > T);
        rd_reg(2'd1, d);
        chk($sformatf("R2 sweep ch=%0d period=%0d", ch, p), d,
            stat(f, f && ch == 0, f && ch == 1, f && ch == 0));
        chk($sformatf("R4 sweep ch=%0d period=%0d", ch, p), {7'b0, on_ref},
            {7'b0, f && ch == 0});
      end
    end

    // R3 R5 R6 recovery on the unselected source
    lf_per = 3; hf_per = 3;
    do_reset();
    hf_per = 0;
    wait_cyc(30);
    rd_reg(2'd1, d); chk("R2 stuck hf", d, stat(1, 0, 1, 0));
    chk("R4 unselected fault no override", {7'b0, on_ref}, 8'h00);
    wr_reg(2'd0, 8'h02);
    wait_cyc(2);
    chk("R6 irq with flag and enable", {7'b0, irq}, 8'h01);
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd1, d); chk("R5 clear ignored while live", d, stat(1, 0, 1, 0));
    hf_per = 4;
    wait_cyc(T - 3);
    rd_reg(2'd1, d); chk("R3 live fault held during recovery", d, stat(1, 0, 1, 0));
    wait_cyc(30);
    rd_reg(2'd1, d); chk("R3 live fault cleared, flag sticky", d, stat(1, 0, 0, 0));
    wr_reg(2'd1, 8'hFF);
    rd_reg(2'd1, d); chk("R5 write one no effect", d, stat(1, 0, 0, 0));
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd1, d); chk("R5 clear accepted", d, 8'h00);
    wait_cyc(2);
    chk("R6 irq drops with flag", {7'b0, irq}, 8'h00);

    // R4 R8 override on the selected source
    wr_reg(2'd0, 8'h00);
    lf_per = 0;
    wait_cyc(30);
    chk("R4 selected fault forces ref", {7'b0, on_ref}, 8'h01);
    rd_reg(2'd1, d); chk("R7 status during lf fault", d, stat(1, 1, 0, 1));
    chk("R6 irq masked by enable", {7'b0, irq}, 8'h00);
    wr_reg(2'd2, 8'h01);
    chk("R8 release ignored during fault", {7'b0, on_ref}, 8'h01);
    lf_per = 3;
    wait_cyc(40);
    rd_reg(2'd1, d); chk("R3 lf recovered", d, stat(1, 0, 0, 1));
    wr_reg(2'd2, 8'h01);
    chk("R8 release ignored while flag set", {7'b0, on_ref}, 8'h01);
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd2, 8'h00);
    chk("R8 write without release bit", {7'b0, on_ref}, 8'h01);
    wr_reg(2'd2, 8'h01);
    chk("R8 release accepted", {7'b0, on_ref}, 8'h00);
    rd_reg(2'd1, d); chk("R8 status after release", d, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule